// File: doc/BRIEF.md
# Strap-Configured Serial Transceiver Core

This block is a full-duplex asynchronous serial transceiver that runs from one system clock. A shared rate generator produces a one-cycle pulse at sixteen times the bit rate, and both the sender and the receiver count sixteen of these pulses per bit. A 2-bit strap input chooses where the configuration comes from:

- it can measure the line and derive the divisor itself,
- it can use one of two built-in divisors, or
- it can take every setting from an external configuration word.

Bytes enter through a valid/ready port. The sender takes a byte in the cycle where both `tx_valid` and `tx_ready` are high. The receiver holds one received byte and keeps `rx_valid` high, with `rx_data` unchanged, until it sees `rx_ready`. If a new frame completes while the byte is still held and not taken, the new frame is dropped. Framing and parity faults appear as single-cycle pulses. The serial input passes through a two-flop synchronizer before use.

Top module: `ustr_core`

## Requirements
- R1: The rate pulse `tick16` is one cycle wide and repeats every divisor+2 system cycles for as long as the divisor is unchanged.
- R2: Strap 2'b01 uses divisor 324, so the pulse period is 326 cycles. Strap 2'b10 uses divisor 24, so the period is 26. In both preset modes the sender and receiver are enabled, two stop bits are sent and parity is off.
- R3: Strap 2'b11 takes its settings from `cfg_word`: bits [11:0] are the divisor, bit 12 enables the sender, bit 13 enables the receiver, bit 14 selects two stop bits (0 gives one), and bits [16:15] set the parity mode (0 none, 1 even, 2 odd, 3 none).
- R4: With strap 2'b00, after reset the block emits no rate pulse, `tx_ready` stays low and the receiver is off. The line must then carry the sync byte 0xFF. The block counts the L system cycles for which the synchronized line is low during that byte's start bit and sets the divisor to floor(L/16)-2, limited at 0. From then on it runs with two stop bits and no parity.
- R5: A sent frame is one low start bit, then 8 data bits with the LSB first, then the parity bit if parity is on, then one or two high stop bits. Each bit lasts 16 rate pulses. The start bit begins on the first rate pulse after the byte is accepted.
- R6: `tx_ready` is high only when the sender is idle, enabled and its rate pulse is running. It is low in the cycle after a byte is accepted.
- R7: `txd` is high during reset, and it stays high whenever the sender is disabled and idle, whatever `tx_valid` does.
- R8: The receiver detects a falling edge and confirms the start bit at its midpoint (8 pulses). It then samples each following bit 16 pulses later and delivers the byte on `rx_data`/`rx_valid`. The byte is held stable until `rx_ready`. A frame that completes while the byte is still held is discarded.
- R9: If the first stop bit is sampled low, `frm_err` pulses for one cycle, and the byte is still delivered.
- R10: With parity on, `par_err` pulses for one cycle when the received parity bit does not match the mode: even makes the total count of ones even, odd makes it odd.
- R11: While the receiver is disabled, frames on `rxd` produce no `rx_valid` and no error pulse.
- R12: Reset is asynchronous and active low. It clears all counters, the measured divisor, the held byte and the error pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 2 | Configuration source select |
| cfg_word | input | 17 | External settings used when strap is 2'b11 |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte to send is present |
| tx_ready | output | 1 | Sender can accept a byte |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte is held |
| rx_ready | input | 1 | Consumer takes the held byte |
| frm_err | output | 1 | One-cycle pulse: stop bit sampled low |
| par_err | output | 1 | One-cycle pulse: parity mismatch |
| tick16 | output | 1 | Rate pulse at 16x the bit rate |

## Verification
The results fall due at different times:

- **Rate pulse:** the spacing between pulses should equal divisor+2 cycles. The bench times the second gap after each configuration change, since the first gap may be short.
- **`tx_ready`:** it falls one cycle after acceptance, and the bench samples it at the next falling clock edge.
- **Sent frame:** the frame starts on the first rate pulse after acceptance. The bench waits for the first low level on `txd`. It then samples 8·P cycles later and every 16·P cycles after that, where P is the pulse period. This puts each sample at the middle of a bit, so the bench does not depend on where the pulse phase happened to lie.
- **Receiver:** its results complete at the middle of the first stop bit, after two synchronizer cycles. The bench drives the whole frame plus four idle cycles before it compares `rx_valid`, the data and the error-pulse counts.

// File: rtl/ustr_pkg.sv
`timescale 1ns/1ps
package ustr_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 12;
  localparam int OSR    = 16;
  localparam int CFG_W  = DIV_W + 5;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE3 = 2'd3
  } par_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             tx_en;
    logic             rx_en;
    logic             two_stop;
    par_e             par;
    logic             run;
  } cfg_t;

  // parity bit value for a byte under the given mode
  function automatic logic par_bit(input par_e m, input logic [DATA_W-1:0] d);
    return (m == PAR_ODD) ? ~^d : ^d;
  endfunction
endpackage

// File: rtl/ustr_cfg.sv
`timescale 1ns/1ps
module ustr_cfg
  import ustr_pkg::*;
#(
  parameter int PRESET_A = 324,
  parameter int PRESET_B = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap,
  input  logic [CFG_W-1:0] word,
  input  logic             rxs,
  output cfg_t             cfg
);
  localparam int SH = $clog2(OSR);
  localparam int CW = DIV_W + SH + 1;

  logic             armed, meas, locked;
  logic [CW-1:0]    cnt;
  logic [DIV_W-1:0] div_q, div_new;
  logic [DIV_W:0]   q, qm2;

  // low time / 16 - 2, limited to the divisor range
  always_comb begin
    q   = cnt[CW-1:SH];
    qm2 = q - (DIV_W+1)'(2);
    if (q < (DIV_W+1)'(2)) div_new = '0;
    else if (qm2[DIV_W])   div_new = '1;
    else                   div_new = qm2[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      meas   <= 1'b0;
      locked <= 1'b0;
      cnt    <= '0;
      div_q  <= '0;
    end else if (strap == 2'b00 && !locked) begin
      if (!meas) begin
        if (rxs) armed <= 1'b1;
        else if (armed) begin
          meas <= 1'b1;
          cnt  <= CW'(1);
        end
      end else if (!rxs) begin
        if (cnt != '1) cnt <= cnt + 1'b1;
      end else begin
        locked <= 1'b1;
        meas   <= 1'b0;
        div_q  <= div_new;
      end
    end
  end

  always_comb begin
    cfg.div      = div_q;
    cfg.tx_en    = 1'b1;
    cfg.rx_en    = 1'b1;
    cfg.two_stop = 1'b1;
    cfg.par      = PAR_NONE;
    cfg.run      = 1'b1;
    case (strap)
      2'b00: begin
        cfg.rx_en = locked;
        cfg.run   = locked;
      end
      2'b01: cfg.div = DIV_W'(PRESET_A);
      2'b10: cfg.div = DIV_W'(PRESET_B);
      default: begin
        cfg.div      = word[DIV_W-1:0];
        cfg.tx_en    = word[DIV_W];
        cfg.rx_en    = word[DIV_W+1];
        cfg.two_stop = word[DIV_W+2];
        cfg.par      = par_e'(word[DIV_W+4:DIV_W+3]);
      end
    endcase
  end

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  assert_halt_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strap == 2'b00 && !locked) |-> (!cfg.run && !cfg.rx_en));
endmodule

// File: rtl/ustr_tick.sv
`timescale 1ns/1ps
module ustr_tick
  import ustr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W:0] per, hi_len, lo_len, cnt;
  logic           phase;

  assign per    = {1'b0, div} + (DIV_W+1)'(2);
  assign hi_len = per >> 1;
  assign lo_len = per - hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      cnt   <= '0;
      tick  <= 1'b0;
    end else if (!run) begin
      phase <= 1'b0;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (!phase) begin
        if (cnt >= lo_len - 1'b1) begin
          phase <= 1'b1;
          cnt   <= '0;
          tick  <= 1'b1;
        end else cnt <= cnt + 1'b1;
      end else begin
        if (cnt >= hi_len - 1'b1) begin
          phase <= 1'b0;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
  end

  // independent spacing monitor
  logic [DIV_W+1:0] gap;
  logic             seen;
  logic [DIV_W-1:0] div_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      seen     <= 1'b0;
      div_prev <= '0;
    end else begin
      div_prev <= div;
      if (!run || div != div_prev) seen <= 1'b0;
      else if (tick) seen <= 1'b1;
      if (tick) gap <= (DIV_W+2)'(1);
      else if (gap != '1) gap <= gap + 1'b1;
    end
  end

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen && run && div == div_prev) |-> (gap == {1'b0, per}));
  assert_tick_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ustr_tx.sv
`timescale 1ns/1ps
module ustr_tx
  import ustr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              run,
  input  logic              two_stop,
  input  par_e              par,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd
);
  localparam int FW = DATA_W + 4;
  localparam int TW = $clog2(OSR);
  localparam int NW = $clog2(FW + 1);

  typedef enum logic [1:0] {T_IDLE, T_WAIT, T_SEND} tst_e;

  tst_e           st;
  logic [FW-1:0]  sh;
  logic [NW-1:0]  nleft;
  logic [TW-1:0]  tcnt;
  logic           has_par;

  assign has_par  = (par == PAR_EVEN) || (par == PAR_ODD);
  assign tx_ready = (st == T_IDLE) && en && run;
  assign txd      = (st == T_SEND) ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= T_IDLE;
      sh    <= '1;
      nleft <= '0;
      tcnt  <= '0;
    end else if (!run) begin
      st    <= T_IDLE;
      sh    <= '1;
      nleft <= '0;
      tcnt  <= '0;
    end else begin
      case (st)
        T_IDLE: if (tx_valid && tx_ready) begin
          sh    <= {2'b11, has_par ? par_bit(par, tx_data) : 1'b1, tx_data, 1'b0};
          nleft <= NW'(DATA_W + 2 + (has_par ? 1 : 0) + (two_stop ? 1 : 0));
          st    <= T_WAIT;
        end
        T_WAIT: if (tick) begin
          st   <= T_SEND;
          tcnt <= '0;
        end
        T_SEND: if (tick) begin
          if (tcnt == TW'(OSR - 1)) begin
            tcnt  <= '0;
            sh    <= {1'b1, sh[FW-1:1]};
            nleft <= nleft - 1'b1;
            if (nleft == NW'(1)) st <= T_IDLE;
          end else tcnt <= tcnt + 1'b1;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assert_ready_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  assert_bits_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_SEND) |-> (nleft != '0));
endmodule

// File: rtl/ustr_rx.sv
`timescale 1ns/1ps
module ustr_rx
  import ustr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  par_e              par,
  input  logic              rxs,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              frm_err,
  output logic              par_err
);
  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rxst_e;

  rxst_e             st;
  logic              prev, pbit, full, has_par, mid, half;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sr, hold;

  assign has_par  = (par == PAR_EVEN) || (par == PAR_ODD);
  assign mid      = tick && (tcnt == TW'(OSR - 1));
  assign half     = tick && (tcnt == TW'(OSR / 2 - 1));
  assign rx_valid = full;
  assign rx_data  = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= R_IDLE;
      prev    <= 1'b1;
      pbit    <= 1'b0;
      full    <= 1'b0;
      tcnt    <= '0;
      bitn    <= '0;
      sr      <= '0;
      hold    <= '0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      prev    <= rxs;
      frm_err <= 1'b0;
      par_err <= 1'b0;
      if (full && rx_ready) full <= 1'b0;
      if (!en) st <= R_IDLE;
      else begin
        case (st)
          R_IDLE: if (prev && !rxs) begin
            st   <= R_START;
            tcnt <= '0;
          end
          R_START: if (half) begin
            tcnt <= '0;
            bitn <= '0;
            st   <= rxs ? R_IDLE : R_DATA;
          end else if (tick) tcnt <= tcnt + 1'b1;
          R_DATA: if (mid) begin
            tcnt <= '0;
            sr   <= {rxs, sr[DATA_W-1:1]};
            bitn <= bitn + 1'b1;
            if (bitn == BW'(DATA_W - 1)) st <= has_par ? R_PAR : R_STOP;
          end else if (tick) tcnt <= tcnt + 1'b1;
          R_PAR: if (mid) begin
            tcnt <= '0;
            pbit <= rxs;
            st   <= R_STOP;
          end else if (tick) tcnt <= tcnt + 1'b1;
          R_STOP: if (mid) begin
            tcnt    <= '0;
            st      <= R_IDLE;
            frm_err <= !rxs;
            par_err <= has_par && (pbit != par_bit(par, sr));
            if (!full || rx_ready) begin
              hold <= sr;
              full <= 1'b1;
            end
          end else if (tick) tcnt <= tcnt + 1'b1;
          default: st <= R_IDLE;
        endcase
      end
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  assert_err_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err || par_err) |-> rx_valid);
  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (!frm_err && !par_err));
endmodule

// File: rtl/ustr_core.sv
`timescale 1ns/1ps
module ustr_core
  import ustr_pkg::*;
#(
  parameter int PRESET_A = 324,
  parameter int PRESET_B = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              frm_err,
  output logic              par_err,
  output logic              tick16
);
  logic rx_m, rx_s, tick;
  cfg_t cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  ustr_cfg #(.PRESET_A(PRESET_A), .PRESET_B(PRESET_B)) u_cfg (
    .clk(clk), .rst_n(rst_n), .strap(strap), .word(cfg_word), .rxs(rx_s), .cfg(cfg)
  );

  ustr_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(cfg.run), .div(cfg.div), .tick(tick)
  );

  ustr_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg.tx_en), .run(cfg.run),
    .two_stop(cfg.two_stop), .par(cfg.par), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd)
  );

  ustr_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg.rx_en), .par(cfg.par), .rxs(rx_s),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .frm_err(frm_err), .par_err(par_err)
  );

  assign tick16 = tick;

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.tx_en && tx_ready == 1'b0 && $past(!cfg.tx_en) && $past(txd)) |-> txd);
endmodule

// File: tb/ustr_core_tb_top.sv
`timescale 1ns/1ps
module ustr_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap;
  logic [16:0] word;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid, tx_ready, txd, rxd, rx_valid, rx_ready, frm_err, par_err, tick16;
  int total = 0, bad = 0, fe_n = 0, pe_n = 0;

  always #2.5 clk = ~clk;

  ustr_core dut_i (
    .clk(clk), .rst_n(rst_n), .strap(strap), .cfg_word(word), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .frm_err(frm_err), .par_err(par_err),
    .tick16(tick16)
  );

  always @(negedge clk) begin
    if (frm_err) fe_n++;
    if (par_err) pe_n++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mk_frame(input logic [7:0] d, input int par, input bit two,
                                  output logic [11:0] f);
    int n;
    f = '1; f[0] = 1'b0; f[8:1] = d; n = 9;
    if (par == 1) begin f[9] = ^d;  n = 10; end
    else if (par == 2) begin f[9] = ~^d; n = 10; end
    n = n + (two ? 2 : 1);
    return n;
  endfunction

  task automatic set_cfg(input int div, input bit txe, input bit rxe, input bit two, input int par);
    word = {par[1:0], two, rxe, txe, div[11:0]};
  endtask

  task automatic tick_gap(output int g);
    do @(negedge clk); while (!tick16);
    g = 0;
    do begin @(negedge clk); g++; end while (!tick16);
  endtask

  task automatic tx_frame(input logic [7:0] d, input int t, input int par, input bit two,
                          input string tag);
    logic [11:0] ef, of;
    int n;
    n = mk_frame(d, par, two, ef);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R6 ready low after accept", tx_ready, 0);
    while (txd) @(negedge clk);
    of = '1;
    repeat (8 * t) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      of[k] = txd;
      if (k < n - 1) repeat (16 * t) @(negedge clk);
    end
    repeat (8 * t + 2) @(negedge clk);
    check(of == ef, tag, int'(of), int'(ef));
  endtask

  task automatic rx_drive(input logic [7:0] d, input int t, input int par, input bit two,
                          input bit bad_stop, input bit bad_par);
    logic [11:0] f;
    int n;
    n = mk_frame(d, par, two, f);
    if (bad_par) f[9] = ~f[9];
    if (bad_stop) f[(par == 0) ? 9 : 10] = 1'b0;
    for (int k = 0; k < n; k++) begin
      rxd = f[k];
      repeat (16 * t) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic pop();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic rx_frame_chk(input logic [7:0] d, input int t, input int par, input bit two,
                              input string tag);
    int fe0, pe0;
    fe0 = fe_n; pe0 = pe_n;
    rx_drive(d, t, par, two, 1'b0, 1'b0);
    check(rx_valid == 1'b1, {tag, " valid"}, rx_valid, 1);
    check(rx_data == d, {tag, " data"}, rx_data, d);
    check(fe_n == fe0 && pe_n == pe0, {tag, " no error pulse"}, fe_n + pe_n, fe0 + pe0);
    pop();
    check(rx_valid == 1'b0, {tag, " released"}, rx_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g, div, par, fe0, pe0;
    bit two, seen_a, seen_b;
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    rxd = 1'b1; strap = 2'b11; tx_valid = 1'b0; rx_ready = 1'b0; tx_data = '0;
    set_cfg(3, 1, 1, 0, 0);
    repeat (5) @(negedge clk);
    // R12: reset state
    check(txd == 1'b1, "R12 txd in reset", txd, 1);
    check(rx_valid == 1'b0, "R12 rx_valid in reset", rx_valid, 0);
    check(tick16 == 1'b0 && frm_err == 1'b0 && par_err == 1'b0, "R12 pulses in reset",
          tick16 + frm_err + par_err, 0);
    rst_n = 1'b1;

    // R1 / R3: external divisor
    tick_gap(g); tick_gap(g);
    check(g == 5, "R1 R3 period for divisor 3", g, 5);
    set_cfg(0, 1, 1, 0, 0);
    tick_gap(g); tick_gap(g);
    check(g == 2, "R1 period for divisor 0", g, 2);

    // R2: presets
    strap = 2'b01;
    tick_gap(g); tick_gap(g);
    check(g == 326, "R2 preset 324", g, 326);
    strap = 2'b10;
    tick_gap(g); tick_gap(g);
    check(g == 26, "R2 preset 24", g, 26);
    tx_frame(8'hA5, 26, 0, 1'b1, "R2 R5 preset send");
    rx_frame_chk(8'h3C, 26, 0, 1'b1, "R2 R8 preset receive");

    // R3 R5 R8 R10: random external settings
    strap = 2'b11;
    for (int i = 0; i < 10; i++) begin
      div = $urandom_range(0, 5);
      par = $urandom_range(0, 2);
      two = 1'($urandom_range(0, 1));
      d   = 8'($urandom);
      set_cfg(div, 1, 1, two, par);
      tick_gap(g); tick_gap(g);
      check(g == div + 2, "R3 random divisor period", g, div + 2);
      tx_frame(d, div + 2, par, two, "R5 random send");
      rx_frame_chk(~d, div + 2, par, two, "R8 R10 random receive");
    end

    // R10: even parity with a wrong parity bit
    set_cfg(2, 1, 1, 0, 1);
    fe0 = fe_n; pe0 = pe_n;
    rx_drive(8'h0F, 4, 1, 1'b0, 1'b0, 1'b1);
    check(pe_n == pe0 + 1, "R10 parity pulse", pe_n - pe0, 1);
    check(rx_valid == 1'b1 && rx_data == 8'h0F, "R10 byte delivered", rx_data, 8'h0F);
    pop();

    // R9: framing error
    set_cfg(2, 1, 1, 0, 0);
    fe0 = fe_n; pe0 = pe_n;
    rx_drive(8'hC3, 4, 0, 1'b0, 1'b1, 1'b0);
    check(fe_n == fe0 + 1, "R9 framing pulse", fe_n - fe0, 1);
    check(pe_n == pe0, "R9 no parity pulse", pe_n - pe0, 0);
    check(rx_valid == 1'b1 && rx_data == 8'hC3, "R9 byte delivered", rx_data, 8'hC3);
    pop();

    // R8: back-pressure, second frame dropped
    rx_drive(8'h11, 4, 0, 1'b0, 1'b0, 1'b0);
    rx_drive(8'h22, 4, 0, 1'b0, 1'b0, 1'b0);
    check(rx_valid == 1'b1 && rx_data == 8'h11, "R8 held byte kept", rx_data, 8'h11);
    pop();
    check(rx_valid == 1'b0, "R8 dropped frame not delivered", rx_valid, 0);

    // R11: receiver disabled
    set_cfg(2, 1, 0, 0, 0);
    fe0 = fe_n; pe0 = pe_n;
    rx_drive(8'h77, 4, 0, 1'b0, 1'b1, 1'b0);
    check(rx_valid == 1'b0, "R11 no valid when off", rx_valid, 0);
    check(fe_n == fe0 && pe_n == pe0, "R11 no pulses when off", fe_n - fe0, 0);

    // R7: sender disabled
    set_cfg(2, 0, 1, 0, 0);
    tx_data = 8'h00; tx_valid = 1'b1;
    seen_a = 1'b0; seen_b = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (!txd) seen_a = 1'b1;
      if (tx_ready) seen_b = 1'b1;
    end
    tx_valid = 1'b0;
    check(!seen_a, "R7 txd stays high when off", seen_a, 0);
    check(!seen_b, "R6 ready low when off", seen_b, 0);

    // R4: automatic rate detection
    strap = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    seen_a = 1'b0; seen_b = 1'b0;
    repeat (200) begin
      @(negedge clk);
      if (tick16) seen_a = 1'b1;
      if (tx_ready) seen_b = 1'b1;
    end
    check(!seen_a, "R4 no pulse before lock", seen_a, 0);
    check(!seen_b, "R4 no ready before lock", seen_b, 0);
    rxd = 1'b0;
    repeat (117) @(negedge clk);
    rxd = 1'b1;
    repeat (10) @(negedge clk);
    tick_gap(g); tick_gap(g);
    check(g == 7, "R4 detected period", g, 7);
    tx_frame(8'h96, 7, 0, 1'b1, "R4 R5 send after lock");
    rx_frame_chk(8'h5A, 7, 0, 1'b1, "R4 R8 receive after lock");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule